// File: doc/BRIEF.md
# Edge-Detect Interrupt Unit

This block watches 24 synchronized input lines, split into three 8-line ports, and records a transition on each line whose sense matches a per-line polarity setting. A captured transition sets a sticky bit in that port's capture register and drives an active-high interrupt request. Software reaches the polarity, enable and capture banks through one shared window of three byte addresses. A page number supplied by the surrounding register logic selects which bank the window reaches. A read-only summary byte shows which ports hold captured bits.

Lines are compared with their own value one clock earlier, so a level held for a single clock is enough to register a transition. The bus side uses plain single-cycle strobes: a write takes effect at the clock edge where `wr_en` is high, and read data is combinational while `rd_en` is high. The block has no stream traffic, so it uses no valid/ready handshake and never back-pressures.

Top module: `edge_irq_unit`

## Requirements
- R1: After reset every polarity, enable and capture bit is 0, `irq` is low, and the summary byte reads 0x00.
- R2: On page 1, a write to offset 0x8+p sets the polarity of port p, with line bit b mapped to data bit b. A 1 captures rising transitions (0 to 1) only; falling transitions on that line are not captured.
- R3: A polarity bit of 0 captures falling transitions (1 to 0) only; rising transitions on that line are not captured.
- R4: On page 2, a write to offset 0x8+p sets the enables of port p. A line whose enable bit is 0 never sets its capture bit.
- R5: Reading offset 0x6 on any page returns bit p set exactly when the capture register of port p is nonzero, with bits 7:3 equal to 0.
- R6: `irq` is high whenever any capture bit is set, and stays high until the last set capture bit is cleared.
- R7: On page 3, offset 0x8+p reads the capture register of port p. Writing it clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R8: If a transition is captured on a line in the same cycle a write clears that line's capture bit, the bit ends up set.
- R9: Clearing an enable bit leaves an already captured bit in place.
- R10: On page 0, offsets 0x8 to 0xA read as 0x00 and writes to them change nothing.
- R11: The polarity and enable banks are write-only: on pages 1 and 2, offsets 0x8 to 0xA read as 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_lvl | input | 24 | Synchronized line levels, port p on bits 8p+7:8p |
| bank_page | input | 2 | Page that selects the bank behind offsets 0x8 to 0xA |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when no readable register is selected |
| irq | output | 1 | Interrupt request, high while any capture bit is set |

## Verification
On every cycle, the embedded assertions check four things. A capture bit appears only on an enabled line. It disappears only after a capture-register write. A detected transition always lands in its bit, even during a clear. Polarity and `irq` change only through their own writes. Whether the right transition sense is captured, the summary byte's encoding, the masked clear, and the paged read-back values (including the page 0 and write-only cases) show up only in the scenarios the bench drives.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  typedef enum logic [1:0] {
    PG_PLAIN = 2'd0,
    PG_POL   = 2'd1,
    PG_EN    = 2'd2,
    PG_ID    = 2'd3
  } bank_page_e;

  localparam int unsigned PEND_OFS  = 6;
  localparam int unsigned BANK_OFS0 = 8;
endpackage

// File: rtl/edge_reg_decode.sv
module edge_reg_decode
  import edge_irq_pkg::*;
#(
  parameter int NPORTS = 3,
  parameter int AW     = 4
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [1:0]        bank_page,
  output logic [NPORTS-1:0] pol_wr,
  output logic [NPORTS-1:0] en_wr,
  output logic [NPORTS-1:0] id_wr,
  output logic [NPORTS-1:0] id_rd,
  output logic              pend_rd
);
  assign pend_rd = rd_en && (addr == AW'(PEND_OFS));

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic ofs_hit;
    assign ofs_hit   = (addr == AW'(BANK_OFS0 + p));
    assign pol_wr[p] = wr_en && ofs_hit && (bank_page == PG_POL);
    assign en_wr[p]  = wr_en && ofs_hit && (bank_page == PG_EN);
    assign id_wr[p]  = wr_en && ofs_hit && (bank_page == PG_ID);
    assign id_rd[p]  = rd_en && ofs_hit && (bank_page == PG_ID);
  end
endmodule

// File: rtl/edge_port_cell.sv
module edge_port_cell #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] line,
  input  logic [PW-1:0] wdata,
  input  logic          pol_wr,
  input  logic          en_wr,
  input  logic          id_wr,
  output logic [PW-1:0] id,
  output logic          any_id
);
  logic [PW-1:0] pol_q, en_q, prev_q;
  logic [PW-1:0] rise, fall, hit, id_kept;

  assign rise    = line & ~prev_q;
  assign fall    = ~line & prev_q;
  assign hit     = en_q & ((pol_q & rise) | (~pol_q & fall));
  assign id_kept = id_wr ? (id & wdata) : id;
  assign any_id  = |id;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_q  <= '0;
      en_q   <= '0;
      prev_q <= '0;
      id     <= '0;
    end else begin
      prev_q <= line;
      if (pol_wr) pol_q <= wdata;
      if (en_wr)  en_q  <= wdata;
      id <= id_kept | hit;
    end
  end

  // R4: a newly set capture bit must belong to a line enabled the cycle before
  assert_capture_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((id & ~$past(id) & ~$past(en_q)) == '0));

  // R7: capture bits only drop after a capture-register write
  assert_clear_only_by_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(id) & ~id) == '0) || $past(id_wr)));

  // R8: a detected transition always lands, even under a clear
  assert_edge_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((id & $past(hit)) == $past(hit)));

  // R10: polarity changes only through its own strobe
  assert_pol_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pol_wr |=> (pol_q == $past(pol_q)));
endmodule

// File: rtl/edge_irq_unit.sv
module edge_irq_unit
  import edge_irq_pkg::*;
#(
  parameter int NPORTS = 3,
  parameter int PW     = 8,
  parameter int AW     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPORTS*PW-1:0] line_lvl,
  input  logic [1:0]           bank_page,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [AW-1:0]        addr,
  input  logic [PW-1:0]        wdata,
  output logic [PW-1:0]        rdata,
  output logic                 irq
);
  localparam int PAD = PW - NPORTS;

  logic [NPORTS-1:0]         pol_wr, en_wr, id_wr, id_rd, pend;
  logic                      pend_rd;
  logic [NPORTS-1:0][PW-1:0] id_bank;

  edge_reg_decode #(.NPORTS(NPORTS), .AW(AW)) u_dec (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .bank_page(bank_page),
    .pol_wr(pol_wr), .en_wr(en_wr), .id_wr(id_wr), .id_rd(id_rd),
    .pend_rd(pend_rd)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_cell
    edge_port_cell #(.PW(PW)) u_cell (
      .clk(clk), .rst_n(rst_n),
      .line(line_lvl[p*PW +: PW]),
      .wdata(wdata),
      .pol_wr(pol_wr[p]), .en_wr(en_wr[p]), .id_wr(id_wr[p]),
      .id(id_bank[p]), .any_id(pend[p])
    );
  end

  assign irq = |pend;

  always_comb begin
    rdata = '0;
    if (pend_rd) rdata = {{PAD{1'b0}}, pend};
    for (int p = 0; p < NPORTS; p++)
      if (id_rd[p]) rdata = id_bank[p];
  end

  // R6: the request drops only after a capture-register write
  assert_irq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(|id_wr));
endmodule

// File: tb/edge_irq_unit_tb.sv
`timescale 1ns/1ps
module edge_irq_unit_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [23:0] line_lvl = '0;
  logic [1:0]  bank_page = '0;
  logic        wr_en = 0, rd_en = 0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;

  int tests = 0, fails = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  edge_irq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .line_lvl(line_lvl), .bank_page(bank_page),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  // monitor: pop expected read data and compare
  always @(negedge clk) begin
    if (rd_en && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      tests++;
      if (rdata !== e) begin
        fails++;
        $display("FAIL %s rdata actual=%02h expected=%02h", t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [1:0] pg, input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bank_page = pg; addr = a; wdata = d; wr_en = 1;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] pg, input logic [3:0] a, input logic [7:0] e, input string t);
    @(posedge clk); #1;
    bank_page = pg; addr = a; rd_en = 1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); #1;
    rd_en = 0;
  endtask

  task automatic set_lines(input logic [23:0] v);
    @(posedge clk); #1;
    line_lvl = v;
    @(posedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    tests++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s irq actual=%0b expected=%0b", t, irq, e);
    end
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk_irq(0, "R1 irq after reset");
    rd(2'd0, 4'h6, 8'h00, "R1 summary after reset");
    rd(2'd3, 4'h8, 8'h00, "R1 id0 after reset");
    rd(2'd3, 4'hA, 8'h00, "R1 id2 after reset");

    wr(2'd1, 4'h8, 8'hFF);  // port0 rising
    wr(2'd1, 4'h9, 8'h00);  // port1 falling
    wr(2'd1, 4'hA, 8'h0F);  // port2 mixed
    wr(2'd2, 4'h8, 8'hFF);
    wr(2'd2, 4'h9, 8'hF0);
    wr(2'd2, 4'hA, 8'hFF);
    rd(2'd1, 4'h8, 8'h00, "R11 polarity bank reads zero");
    rd(2'd2, 4'h9, 8'h00, "R11 enable bank reads zero");

    set_lines(24'h00_00_05);
    set_lines(24'h00_FF_05);
    rd(2'd3, 4'h9, 8'h00, "R3 rising ignored on falling polarity");
    set_lines(24'h00_0F_05);
    set_lines(24'h00_00_05);
    rd(2'd3, 4'h8, 8'h05, "R2 rising captured");
    rd(2'd3, 4'h9, 8'hF0, "R3 falling captured and R4 disabled lines ignored");
    rd(2'd1, 4'h6, 8'h03, "R5 summary two ports");
    chk_irq(1, "R6 irq with captures");
    set_lines(24'h00_00_00);
    rd(2'd3, 4'h8, 8'h05, "R2 falling ignored on rising polarity");

    wr(2'd3, 4'h8, 8'hFE);
    rd(2'd3, 4'h8, 8'h04, "R7 masked clear");
    wr(2'd3, 4'h9, 8'h0F);
    rd(2'd3, 4'h9, 8'h00, "R7 clear written zeros");
    rd(2'd0, 4'h6, 8'h01, "R5 summary one port");
    chk_irq(1, "R6 irq held while one bit left");
    wr(2'd3, 4'h8, 8'h00);
    chk_irq(0, "R6 irq drops after last clear");
    rd(2'd2, 4'h6, 8'h00, "R5 summary empty");

    set_lines(24'h02_00_00);
    wr(2'd2, 4'hA, 8'h00);
    rd(2'd3, 4'hA, 8'h02, "R9 capture survives enable clear");
    wr(2'd3, 4'hA, 8'h00);

    // R8: clear write and new edge in the same cycle
    @(posedge clk); #1;
    bank_page = 2'd3; addr = 4'h8; wdata = 8'h00; wr_en = 1;
    line_lvl = 24'h02_00_01;
    @(posedge clk); #1;
    wr_en = 0;
    rd(2'd3, 4'h8, 8'h01, "R8 edge beats clear");
    chk_irq(1, "R8 irq from edge during clear");

    set_lines(24'h02_00_03);
    wr(2'd0, 4'h8, 8'h00);
    rd(2'd3, 4'h8, 8'h03, "R10 page0 write ignored");
    rd(2'd0, 4'h8, 8'h00, "R10 page0 reads zero");
    wr(2'd3, 4'h8, 8'h00);
    chk_irq(0, "R6 irq low at end");

    repeat (2) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule